// File: doc/BRIEF.md
# Supply Overcurrent and Latch-up Guard

This block watches a stream of channel-tagged current and voltage samples from an ADC front end and compares each one with a threshold that software programs for that channel. The first sample above its threshold raises a warning and cuts the supply of the device under test on the next clock edge. Software may also ask for a power cycle at any time while the supply runs normally.

After an off period and a recovery delay, both programmable in clock cycles, the supply comes back. If the cut was caused by an over-threshold sample, the block waits for the next sample on the same channel. A value back within limits means the high-current state went away with the power cycle, so the event is counted as a latch-up and normal running resumes. A value still above the limit means the damage is permanent: the supply stays off until reset. Samples arrive about every 50 ms. Channels 0 to 15 deliver 10-bit samples that are left-aligned against 12-bit thresholds. Channels 16 to 23 deliver full 12-bit samples.

Top module: `supply_guard`

## Requirements
- R1: After reset, supply_en is 1, and warn, damage, latchup_pulse and latchup_count are all 0. Every threshold resets to all ones.
- R2: A sample trips only when it is strictly greater than its channel's threshold. On channels below NNARROW (0 to 15), only smp_data[9:0] is used, compared as {smp_data[9:0],2'b00}. Channels 16 to 23 compare all 12 bits.
- R3: Once an over-threshold sample is accepted in normal running, supply_en is 0 and warn is 1 after that same clock edge. trip_chan holds the channel number.
- R4: warn stays at 1 until warn_clr is asserted. If a new warning and warn_clr arrive in the same cycle, the warning wins.
- R5: After a trip or a power cycle, supply_en stays 0 for exactly off_cycles clocks (minimum 1). It then returns to 1.
- R6: After a trip, the next sample on the tripped channel that arrives after the recovery window is checked. If it is at or below the threshold, latchup_pulse is 1 for one cycle, latchup_count increments, and normal running resumes.
- R7: If that check sample is still above the threshold, damage is set and supply_en stays 0. cycle_req then has no effect until reset.
- R8: latchup_count saturates at its maximum value 2^LCW-1.
- R9: cycle_req in normal running power-cycles the supply with the R5 timing. It produces no latch-up classification.
- R10: Samples and threshold writes whose channel number is NCH or more are ignored.
- R11: Samples accepted during the off period or the settle_cycles recovery window cause no trip and no classification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_chan | input | CHW | Channel of the sample |
| smp_data | input | TW | Sample value (10-bit channels use the low bits) |
| thr_we | input | 1 | Threshold write strobe |
| thr_chan | input | CHW | Channel whose threshold is written |
| thr_value | input | TW | New threshold |
| off_cycles | input | TMRW | Power-off duration in clocks |
| settle_cycles | input | TMRW | Recovery delay before the check |
| cycle_req | input | 1 | Power-cycle request |
| warn_clr | input | 1 | Clears the warning flag |
| supply_en | output | 1 | Supply enable for the device under test |
| warn | output | 1 | Sticky warning |
| damage | output | 1 | Persistent high current seen after a cycle |
| latchup_pulse | output | 1 | One-cycle latch-up classification |
| latchup_count | output | LCW | Saturating latch-up count |
| trip_chan | output | CHW | Channel of the last trip |

## Verification
A wrong comparator or threshold entry shows up one clock after the offending sample: supply_en either drops when it should not, or stays high when it should drop. A wrong off-time or settle counter shifts the edge at which supply_en comes back, and the bench measures that edge in whole cycles. A state machine that forgets which channel tripped, or mixes up the two outcomes, shows up on latchup_pulse, latchup_count or damage in the cycle after the check sample.

// File: rtl/supply_guard.sv
module supply_guard #(
  parameter int NCH     = 24,
  parameter int NNARROW = 16,
  parameter int NW      = 10,
  parameter int TW      = 12,
  parameter int TMRW    = 16,
  parameter int LCW     = 4,
  localparam int CHW    = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_valid,
  input  logic [CHW-1:0]  smp_chan,
  input  logic [TW-1:0]   smp_data,
  input  logic            thr_we,
  input  logic [CHW-1:0]  thr_chan,
  input  logic [TW-1:0]   thr_value,
  input  logic [TMRW-1:0] off_cycles,
  input  logic [TMRW-1:0] settle_cycles,
  input  logic            cycle_req,
  input  logic            warn_clr,
  output logic            supply_en,
  output logic            warn,
  output logic            damage,
  output logic            latchup_pulse,
  output logic [LCW-1:0]  latchup_count,
  output logic [CHW-1:0]  trip_chan
);

  typedef enum logic [2:0] {ST_RUN, ST_OFF, ST_SETTLE, ST_CHECK, ST_DEAD} st_t;

  st_t            st;
  logic [TMRW-1:0] tmr;
  logic            pending;
  logic [TW-1:0]   thr_q [NCH];

  wire smp_in   = 32'(smp_chan) < NCH;
  wire narrow   = 32'(smp_chan) < NNARROW;
  wire [TW-1:0] smp_al  = narrow ? {smp_data[NW-1:0], {(TW-NW){1'b0}}} : smp_data;
  wire [TW-1:0] thr_sel = smp_in ? thr_q[smp_chan] : {TW{1'b1}};
  wire over     = smp_valid && smp_in && (smp_al > thr_sel);
  wire own_chan = smp_valid && smp_in && (smp_chan == trip_chan);
  wire [LCW-1:0] cnt_max = {LCW{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) thr_q[i] <= {TW{1'b1}};
    end else if (thr_we && 32'(thr_chan) < NCH) begin
      thr_q[thr_chan] <= thr_value;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= ST_RUN;
      tmr           <= '0;
      pending       <= 1'b0;
      supply_en     <= 1'b1;
      warn          <= 1'b0;
      damage        <= 1'b0;
      latchup_pulse <= 1'b0;
      latchup_count <= '0;
      trip_chan     <= '0;
    end else begin
      latchup_pulse <= 1'b0;
      if (warn_clr) warn <= 1'b0;
      case (st)
        ST_RUN: begin
          if (over) begin
            st        <= ST_OFF;
            supply_en <= 1'b0;
            warn      <= 1'b1;
            trip_chan <= smp_chan;
            pending   <= 1'b1;
            tmr       <= off_cycles;
          end else if (cycle_req) begin
            st        <= ST_OFF;
            supply_en <= 1'b0;
            pending   <= 1'b0;
            tmr       <= off_cycles;
          end
        end
        ST_OFF: begin
          if (tmr <= 1) begin
            st        <= ST_SETTLE;
            supply_en <= 1'b1;
            tmr       <= settle_cycles;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_SETTLE: begin
          if (tmr <= 1) st <= pending ? ST_CHECK : ST_RUN;
          else          tmr <= tmr - 1'b1;
        end
        ST_CHECK: begin
          if (own_chan) begin
            if (over) begin
              st        <= ST_DEAD;
              supply_en <= 1'b0;
              damage    <= 1'b1;
              warn      <= 1'b1;
            end else begin
              st            <= ST_RUN;
              pending       <= 1'b0;
              latchup_pulse <= 1'b1;
              if (latchup_count != cnt_max) latchup_count <= latchup_count + 1'b1;
            end
          end else if (over) begin
            st        <= ST_OFF;
            supply_en <= 1'b0;
            warn      <= 1'b1;
            trip_chan <= smp_chan;
            tmr       <= off_cycles;
          end
        end
        default: begin
          supply_en <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/supply_guard_chk.sv
module supply_guard_chk #(
  parameter int LCW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           warn_clr,
  input logic           supply_en,
  input logic           warn,
  input logic           damage,
  input logic           latchup_pulse,
  input logic [LCW-1:0] latchup_count
);

  // R3
  warn_rise_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn) |-> !supply_en);

  // R4
  warn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warn && !warn_clr) |=> warn);

  // R7
  damage_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    damage |=> (damage && !supply_en));

  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latchup_pulse |=> !latchup_pulse);

  // R6
  pulse_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latchup_pulse |-> supply_en);

  // R8
  count_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(latchup_count) |-> latchup_pulse);

  // R8
  count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latchup_pulse |-> (latchup_count >= $past(latchup_count)));

endmodule

bind supply_guard supply_guard_chk #(.LCW(LCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .warn_clr(warn_clr), .supply_en(supply_en),
  .warn(warn), .damage(damage), .latchup_pulse(latchup_pulse),
  .latchup_count(latchup_count)
);

// File: tb/test_supply_guard.sv
module test_supply_guard;
  localparam int NCH = 24;
  localparam int CHW = 5;
  localparam int TW = 12;
  localparam int TMRW = 16;
  localparam int LCW = 2;
  localparam int OFFN = 5;
  localparam int SETN = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic smp_valid = 0;
  logic [CHW-1:0] smp_chan = '0;
  logic [TW-1:0] smp_data = '0;
  logic thr_we = 0;
  logic [CHW-1:0] thr_chan = '0;
  logic [TW-1:0] thr_value = '0;
  logic [TMRW-1:0] off_cycles = TMRW'(OFFN);
  logic [TMRW-1:0] settle_cycles = TMRW'(SETN);
  logic cycle_req = 0;
  logic warn_clr = 0;
  logic supply_en, warn, damage, latchup_pulse;
  logic [LCW-1:0] latchup_count;
  logic [CHW-1:0] trip_chan;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  supply_guard #(.NCH(NCH), .TW(TW), .TMRW(TMRW), .LCW(LCW)) i_supply_guard (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_data(smp_data), .thr_we(thr_we), .thr_chan(thr_chan),
    .thr_value(thr_value), .off_cycles(off_cycles),
    .settle_cycles(settle_cycles), .cycle_req(cycle_req),
    .warn_clr(warn_clr), .supply_en(supply_en), .warn(warn),
    .damage(damage), .latchup_pulse(latchup_pulse),
    .latchup_count(latchup_count), .trip_chan(trip_chan)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int ch, input int val);
    @(negedge clk);
    smp_valid = 1; smp_chan = CHW'(ch); smp_data = TW'(val);
    @(negedge clk);
    smp_valid = 0;
  endtask

  task automatic wr_thr(input int ch, input int val);
    @(negedge clk);
    thr_we = 1; thr_chan = CHW'(ch); thr_value = TW'(val);
    @(negedge clk);
    thr_we = 0;
  endtask

  task automatic pulse_cycle_req();
    @(negedge clk); cycle_req = 1;
    @(negedge clk); cycle_req = 0;
  endtask

  task automatic count_off(input string req);
    int n = 0;
    while (!supply_en && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk(req, n, OFFN);
  endtask

  task automatic t_reset();
    chk("R1 supply_en", supply_en, 1);
    chk("R1 warn", warn, 0);
    chk("R1 damage", damage, 0);
    chk("R1 pulse", latchup_pulse, 0);
    chk("R1 count", latchup_count, 0);
  endtask

  task automatic t_compare();
    send(0, 12'h3FF);
    chk("R1 default threshold max", supply_en, 1);
    wr_thr(3, 12'h200);
    wr_thr(20, 12'h7FF);
    wr_thr(27, 12'h000);
    send(3, 12'h080);
    chk("R2 narrow equal no trip", supply_en, 1);
    send(3, 12'hC80);
    chk("R2 narrow upper bits ignored", supply_en, 1);
    send(20, 12'h7FF);
    chk("R2 wide equal no trip", supply_en, 1);
    send(27, 12'hFFF);
    chk("R10 out-of-range sample ignored", supply_en, 1);
    chk("R10 no warn", warn, 0);
  endtask

  task automatic t_latchup();
    send(20, 12'h800);
    chk("R3 supply off", supply_en, 0);
    chk("R3 warn", warn, 1);
    chk("R3 trip_chan", trip_chan, 20);
    count_off("R5 off duration");
    send(20, 12'hFFF);
    chk("R11 settle sample ignored", supply_en, 1);
    chk("R11 no damage", damage, 0);
    repeat (SETN + 1) @(negedge clk);
    send(20, 12'h100);
    chk("R6 latchup pulse", latchup_pulse, 1);
    chk("R6 count", latchup_count, 1);
    chk("R6 supply on", supply_en, 1);
    chk("R4 warn held", warn, 1);
    @(negedge clk);
    chk("R6 pulse one cycle", latchup_pulse, 0);
    warn_clr = 1;
    @(negedge clk);
    warn_clr = 0;
    chk("R4 warn cleared", warn, 0);
  endtask

  task automatic t_cycle();
    pulse_cycle_req();
    chk("R9 supply off", supply_en, 0);
    count_off("R9 off duration");
    repeat (SETN + 3) @(negedge clk);
    chk("R9 no pulse", latchup_pulse, 0);
    chk("R9 count unchanged", latchup_count, 1);
    chk("R9 no warn", warn, 0);
    send(20, 12'h010);
    chk("R9 normal running", supply_en, 1);
    send(20, 12'h900);
    chk("R9 trips again in run", supply_en, 0);
    count_off("R5 second off duration");
    repeat (SETN + 1) @(negedge clk);
    send(20, 12'h000);
    chk("R6 second latchup", latchup_count, 2);
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 2; k++) begin
      send(3, 12'h081);
      chk("R2 narrow above trips", supply_en, 0);
      count_off("R5 off duration");
      repeat (SETN + 1) @(negedge clk);
      send(3, 12'h010);
    end
    chk("R8 count saturated", latchup_count, 3);
  endtask

  task automatic t_damage();
    send(3, 12'h0FF);
    count_off("R5 off duration");
    repeat (SETN + 1) @(negedge clk);
    send(3, 12'h0FF);
    chk("R7 damage", damage, 1);
    chk("R7 supply off", supply_en, 0);
    chk("R7 no pulse", latchup_pulse, 0);
    chk("R8 count stays", latchup_count, 3);
    pulse_cycle_req();
    repeat (OFFN + SETN + 5) @(negedge clk);
    chk("R7 cycle ignored", supply_en, 0);
    chk("R7 damage held", damage, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_compare();
    t_latchup();
    t_cycle();
    t_saturate();
    t_damage();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule